// File: doc/BRIEF.md
# Serial Wiper Step Decoder

This block handles the fine-tuning phase of a two-wire controlled digital potentiometer. The instruction decoder pulses `arm_i` once it has acknowledged the step instruction, and drives the potentiometer index from that instruction on `pot_sel_i` in the same cycle. From then on each high phase of the serial clock counts as one step. The serial data level seen when the clock rises picks the direction: high moves the wiper one segment toward the high terminal, and low moves it one segment toward the low terminal.

No bytes are framed and no acknowledge is sent while the block is stepping. The phase runs until a STOP or a START condition shows up on the bus. A step is reported with a single-cycle `step_o` pulse, which carries the direction, the latched potentiometer index and the saturated new wiper value. The wiper register sits outside this block. It takes the new value and feeds its contents back on `wiper_i`. Stepping only touches that volatile register and never starts a store cycle.

Top module: `wstep_top`

## Requirements
- R1: After reset `active_o`, `step_o` and `wiper_nxt_o` are all zero.
- R2: A one-cycle `arm_i` while idle sets `active_o` from the next cycle on. The `pot_sel_i` value present with `arm_i` is latched, and later changes of `pot_sel_i` have no effect until the phase ends.
- R3: An SCL high phase that begins with SDA high produces a step with `step_up_o`=1 and `wiper_nxt_o` equal to the selected `wiper_i` slice plus one.
- R4: An SCL high phase that begins with SDA low produces a step with `step_up_o`=0 and `wiper_nxt_o` equal to the selected slice minus one.
- R5: Each SCL high phase gives exactly one `step_o` pulse, however long the phase lasts. The pulse is one cycle wide and appears in the cycle after SCL is seen low.
- R6: A step up from the all-ones value gives all ones. A step down from zero gives zero. The value never wraps.
- R7: A STOP condition (SDA rising while SCL stays high) clears `active_o`. After that, SCL pulses produce no step.
- R8: A START condition (SDA falling while SCL stays high) clears `active_o`. The high phase it occurs in produces no step.
- R9: The wiper slice `k` of `wiper_i` (bits `k*WIDTH` upward) is used for the latched index `k`, and `step_pot_o` reports `k`.
- R10: While not active, SCL pulses produce no step whatever the SDA level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronised serial clock |
| sda_i | input | 1 | Synchronised serial data |
| arm_i | input | 1 | Pulse: step instruction acknowledged |
| pot_sel_i | input | $clog2(NPOT) | Potentiometer index from the instruction |
| wiper_i | input | NPOT*WIDTH | Current wiper values, slice k for potentiometer k |
| active_o | output | 1 | Stepping phase in progress |
| step_o | output | 1 | One-cycle step strobe |
| step_up_o | output | 1 | Direction of the step: 1 up, 0 down |
| step_pot_o | output | $clog2(NPOT) | Potentiometer the step applies to |
| wiper_nxt_o | output | WIDTH | New saturated wiper value |

## Verification
The bench uses the default parameters: an 8-bit wiper and two potentiometers. With these values both ends of the range are only a few steps away from preloaded values such as FEh and 01h, so saturation can be reached directly. Both select values are also covered, which shows that the slice is chosen from the latched index and not from the live select input. Long high phases, START in the middle of a phase, STOP, and pulses sent while idle are driven as separate directed scenarios.

// File: rtl/wstep_pkg.sv
package wstep_pkg;
    typedef enum logic {
        MODE_IDLE = 1'b0,
        MODE_STEP = 1'b1
    } mode_e;
endpackage

// File: rtl/wstep_line_watch.sv
module wstep_line_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    typedef struct packed {
        logic scl;
        logic sda;
    } line_s;

    line_s line_d, line_q;

    always_comb begin
        line_d.scl = scl_i;
        line_d.sda = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) line_q <= '{scl: 1'b1, sda: 1'b1};
        else        line_q <= line_d;
    end

    // bus conditions only count while SCL was high in both samples
    assign scl_rise_o = scl_i & ~line_q.scl;
    assign scl_fall_o = ~scl_i & line_q.scl;
    assign start_o    = scl_i & line_q.scl & line_q.sda & ~sda_i;
    assign stop_o     = scl_i & line_q.scl & ~line_q.sda & sda_i;
endmodule

// File: rtl/wstep_sat.sv
module wstep_sat #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic             up_i,
    output logic [WIDTH-1:0] nxt_o
);
    localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    always_comb begin
        if (up_i) nxt_o = (cur_i == TOP) ? cur_i : cur_i + ONE;
        else      nxt_o = (cur_i == '0)  ? cur_i : cur_i - ONE;
    end
endmodule

// File: rtl/wstep_engine.sv
module wstep_engine #(
    parameter int NPOT  = 2,
    parameter int WIDTH = 8,
    localparam int SELW = $clog2(NPOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_i,
    input  logic [SELW-1:0]  pot_sel_i,
    input  logic             sda_i,
    input  logic             scl_rise_i,
    input  logic             scl_fall_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [WIDTH-1:0] stepped_i,
    output logic             active_o,
    output logic             step_o,
    output logic             step_up_o,
    output logic             dir_o,
    output logic [SELW-1:0]  pot_o,
    output logic [WIDTH-1:0] val_o
);
    import wstep_pkg::*;

    typedef struct packed {
        mode_e             mode;
        logic [SELW-1:0]   pot;
        logic              dir;
        logic              pend;
        logic              step;
        logic              up;
        logic [WIDTH-1:0]  val;
    } eng_s;

    eng_s eng_d, eng_q;

    always_comb begin
        eng_d      = eng_q;
        eng_d.step = 1'b0;
        unique case (eng_q.mode)
            MODE_IDLE: begin
                if (arm_i) begin
                    eng_d.mode = MODE_STEP;
                    eng_d.pot  = pot_sel_i;
                    eng_d.pend = 1'b0;
                end
            end
            MODE_STEP: begin
                if (start_i || stop_i) begin
                    eng_d.mode = MODE_IDLE;
                    eng_d.pend = 1'b0;
                end else if (scl_rise_i) begin
                    eng_d.pend = 1'b1;
                    eng_d.dir  = sda_i;
                end else if (scl_fall_i && eng_q.pend) begin
                    eng_d.pend = 1'b0;
                    eng_d.step = 1'b1;
                    eng_d.up   = eng_q.dir;
                    eng_d.val  = stepped_i;
                end
            end
            default: eng_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '{mode: MODE_IDLE, default: '0};
        else        eng_q <= eng_d;
    end

    assign active_o  = (eng_q.mode == MODE_STEP);
    assign step_o    = eng_q.step;
    assign step_up_o = eng_q.up;
    assign dir_o     = eng_q.dir;
    assign pot_o     = eng_q.pot;
    assign val_o     = eng_q.val;

    // R5: a step can never be followed directly by another
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.step |=> !eng_q.step);

    // R10: steps only come out of the stepping mode
    p_step_needs_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_q.step |-> $past(eng_q.mode == MODE_STEP));

    // R7: STOP ends the phase without a step
    p_stop_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mode == MODE_STEP && stop_i) |=> (eng_q.mode == MODE_IDLE && !eng_q.step));

    // R8: START ends the phase without a step
    p_start_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mode == MODE_STEP && start_i) |=> (eng_q.mode == MODE_IDLE && !eng_q.step));

    // R2: select stays latched during the phase
    p_pot_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_q.mode == MODE_STEP && $past(eng_q.mode == MODE_STEP)) |-> $stable(eng_q.pot));
endmodule

// File: rtl/wstep_top.sv
module wstep_top #(
    parameter int NPOT  = 2,
    parameter int WIDTH = 8,
    localparam int SELW = $clog2(NPOT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    input  logic                  arm_i,
    input  logic [SELW-1:0]       pot_sel_i,
    input  logic [NPOT*WIDTH-1:0] wiper_i,
    output logic                  active_o,
    output logic                  step_o,
    output logic                  step_up_o,
    output logic [SELW-1:0]       step_pot_o,
    output logic [WIDTH-1:0]      wiper_nxt_o
);
    logic             scl_rise, scl_fall, start_det, stop_det;
    logic             dir_q;
    logic [WIDTH-1:0] cur_sel, stepped;
    logic [WIDTH-1:0] cur_arr [NPOT];

    for (genvar k = 0; k < NPOT; k++) begin : g_slice
        assign cur_arr[k] = wiper_i[k*WIDTH +: WIDTH];
    end

    assign cur_sel = cur_arr[step_pot_o];

    wstep_line_watch u_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    wstep_sat #(.WIDTH(WIDTH)) u_sat (
        .cur_i (cur_sel),
        .up_i  (dir_q),
        .nxt_o (stepped)
    );

    wstep_engine #(.NPOT(NPOT), .WIDTH(WIDTH)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm_i      (arm_i),
        .pot_sel_i  (pot_sel_i),
        .sda_i      (sda_i),
        .scl_rise_i (scl_rise),
        .scl_fall_i (scl_fall),
        .start_i    (start_det),
        .stop_i     (stop_det),
        .stepped_i  (stepped),
        .active_o   (active_o),
        .step_o     (step_o),
        .step_up_o  (step_up_o),
        .dir_o      (dir_q),
        .pot_o      (step_pot_o),
        .val_o      (wiper_nxt_o)
    );

    // R6: an upward step never lands on zero
    p_up_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && step_up_o) |-> (wiper_nxt_o != '0));

    // R6: a downward step never lands on all ones
    p_dn_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !step_up_o) |-> (wiper_nxt_o != {WIDTH{1'b1}}));
endmodule

// File: tb/wstep_top_tb_top.sv
module wstep_top_tb_top;
    localparam int NPOT  = 2;
    localparam int WIDTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1, arm = 1'b0;
    logic [0:0] pot_sel = 1'b0;
    logic [WIDTH-1:0] model [NPOT];
    logic [NPOT*WIDTH-1:0] wiper;
    logic active, step, step_up;
    logic [0:0] step_pot;
    logic [WIDTH-1:0] wiper_nxt;
    int nvec = 0, nbad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    always_comb wiper = {model[1], model[0]};

    wstep_top #(.NPOT(NPOT), .WIDTH(WIDTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .arm_i(arm),
        .pot_sel_i(pot_sel), .wiper_i(wiper), .active_o(active), .step_o(step),
        .step_up_o(step_up), .step_pot_o(step_pot), .wiper_nxt_o(wiper_nxt)
    );

    task automatic chk(string req, int act, int exp);
        nvec++;
        if (act != exp) begin
            nbad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [WIDTH-1:0] sat_ref(logic [WIDTH-1:0] v, logic up);
        if (up) return (v == 8'hFF) ? v : v + 8'd1;
        return (v == 8'h00) ? v : v - 8'd1;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 active", int'(active), 0);
        chk("R1 step", int'(step), 0);
        chk("R1 value", int'(wiper_nxt), 0);
    endtask

    // from idle-high bus: START then SCL low
    task automatic t_restart();
        @(negedge clk) sda = 1'b0;
        @(negedge clk) scl = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_arm(int p);
        @(negedge clk) begin arm = 1'b1; pot_sel = 1'(p); end
        @(negedge clk) begin arm = 1'b0; pot_sel = 1'(~p); end
        chk("R2 active after arm", int'(active), 1);
    endtask

    // one SCL high phase; SDA set while SCL low
    task automatic t_pulse(string req, logic lvl, int hold, bit expect_step, int p);
        logic [WIDTH-1:0] exp_v;
        @(negedge clk) sda = lvl;
        @(negedge clk) scl = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk({req, " R5 no step while high"}, int'(step), 0);
        end
        scl = 1'b0;
        @(negedge clk);
        if (expect_step) begin
            exp_v = sat_ref(model[p], lvl);
            chk({req, " step"}, int'(step), 1);
            chk({req, " dir"}, int'(step_up), int'(lvl));
            chk({req, " R9 pot"}, int'(step_pot), p);
            chk({req, " value"}, int'(wiper_nxt), int'(exp_v));
            model[p] = exp_v;
        end else begin
            chk({req, " no step"}, int'(step), 0);
        end
        @(negedge clk);
        chk({req, " R5 single pulse"}, int'(step), 0);
    endtask

    task automatic t_stop();
        @(negedge clk) sda = 1'b0;
        @(negedge clk) scl = 1'b1;
        @(negedge clk) sda = 1'b1;
        @(negedge clk);
        chk("R7 stop clears active", int'(active), 0);
        chk("R7 stop no step", int'(step), 0);
    endtask

    task automatic t_idle_pulses();
        t_restart();
        t_pulse("R10 idle up", 1'b1, 2, 1'b0, 0);
        t_pulse("R10 idle down", 1'b0, 2, 1'b0, 0);
        chk("R10 still idle", int'(active), 0);
    endtask

    task automatic t_basic_steps();
        model[0] = 8'h40;
        model[1] = 8'h90;
        t_arm(0);
        t_pulse("R3 up", 1'b1, 1, 1'b1, 0);
        t_pulse("R3 up", 1'b1, 2, 1'b1, 0);
        t_pulse("R3 up", 1'b1, 1, 1'b1, 0);
        chk("R3 model 43", int'(model[0]), 8'h43);
        t_pulse("R4 down", 1'b0, 1, 1'b1, 0);
        t_pulse("R4 down", 1'b0, 3, 1'b1, 0);
        t_pulse("R5 long high", 1'b1, 9, 1'b1, 0);
        chk("R9 other pot untouched", int'(model[1]), 8'h90);
        t_stop();
        t_restart();
        t_pulse("R7 after stop", 1'b1, 2, 1'b0, 0);
    endtask

    task automatic t_top_sat();
        model[1] = 8'hFE;
        t_arm(1);
        t_pulse("R6 up to FF", 1'b1, 1, 1'b1, 1);
        t_pulse("R6 hold FF", 1'b1, 1, 1'b1, 1);
        t_pulse("R6 hold FF", 1'b1, 2, 1'b1, 1);
        chk("R6 top", int'(model[1]), 8'hFF);
        t_pulse("R4 down from FF", 1'b0, 1, 1'b1, 1);
        // R8: START inside a high phase aborts it
        @(negedge clk) sda = 1'b1;
        @(negedge clk) scl = 1'b1;
        @(negedge clk) sda = 1'b0;
        @(negedge clk);
        chk("R8 start clears active", int'(active), 0);
        scl = 1'b0;
        @(negedge clk);
        chk("R8 no step on abort", int'(step), 0);
        @(negedge clk);
        chk("R8 no step later", int'(step), 0);
        t_pulse("R8 after start", 1'b0, 1, 1'b0, 1);
    endtask

    task automatic t_bottom_sat();
        model[0] = 8'h01;
        t_arm(0);
        t_pulse("R6 down to 00", 1'b0, 1, 1'b1, 0);
        t_pulse("R6 hold 00", 1'b0, 1, 1'b1, 0);
        chk("R6 bottom", int'(model[0]), 8'h00);
        t_pulse("R3 up from 00", 1'b1, 1, 1'b1, 0);
        t_stop();
    endtask

    initial begin
        model[0] = '0;
        model[1] = '0;
        t_reset();
        t_idle_pulses();
        t_basic_steps();
        t_top_sat();
        t_bottom_sat();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end
endmodule